// File: doc/BRIEF.md
# Row-Drive Pattern Memory Initializer

This block is a sequencer that fills the row-drive region of a display bitmap memory of 165 columns by 65 lines. Some panel driver pins can act as row (common) drivers instead of column drivers. When they do, the bitmap columns behind those pins must hold a one-hot selection pattern: on each display line a single 1 sits at the column wired to that panel line, and every other bit of that line inside the row-drive region is 0. Which columns form the region, and how many lines are used, depend on a two-bit mode code.

A controller pulses `start` with a mode code. The block drops the memory's write-protect flag and then issues one write per clock through a plain write port: line address, column address, data bit and strobe. Columns are scanned in ascending order within a line, and lines are scanned in ascending order. After the last write it raises the protect flag again and pulses `done`. When the mode has no row-drive region, no writes are issued and `done` follows at once. Only the built-in panel wiring described below is supported.

Top module: `rdi_row_init`

## Requirements
- R1: While `rst` is high and in the cycle after it, `protect` is 1 and `wr_en`, `busy` and `done` are 0. A reset during a fill abandons the fill.
- R2: Mode code 0 (all pins drive columns) issues no write, keeps `protect` at 1 and pulses `done` for one cycle in the cycle after `start` is accepted.
- R3: Mode code 1 (65 rows on the right) writes lines 0 to 64 at columns 100 to 164, which is 4225 writes.
- R4: Mode code 3 (33 rows on the right) writes only lines 0 to 32 at columns 132 to 164, which is 1089 writes.
- R5: Mode code 2 (65 rows split left and right) writes lines 0 to 64 at columns 0 to 31 and 132 to 164, which is 4225 writes.
- R6: The data bit is 1 only at the mapped column and 0 elsewhere. In modes 1 and 3, line j maps to column 164-j. In mode 2, lines 0 to 32 map to 164-j and lines 33 to 64 map to 64-j.
- R7: Writes come one per clock with no gap. Columns ascend within a line, and the line number increases by exactly one from line to line.
- R8: `protect` falls in the cycle after `start` is accepted, one cycle before the first write. It stays 0 through every write. It rises together with a one-cycle `done` pulse in the cycle after the last write, so a fill of N writes ends N+1 cycles after `start` is accepted.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored, and the fill in progress keeps its original mode.
- R10: `busy` is 1 from the cycle after `start` is accepted until the cycle in which `done` pulses, where it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when idle |
| mode | input | 2 | Row-output mode code, sampled with `start` |
| wr_en | output | 1 | Memory write strobe |
| wr_line | output | 7 | Line address of the write |
| wr_col | output | 8 | Column address of the write |
| wr_data | output | 1 | Bit value written |
| protect | output | 1 | Row-data write-protect flag, 1 = protected |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the protect handshake: no write while protected, protected at `done`, and `protect` already low when `busy` rises. They also check the scan order, the column bound, the line limit of the 33-row mode, the exclusivity of `busy` and `done`, and that a start pulse while busy leaves the captured mode untouched. Only the bench scenarios can show that each mode produces the right number of writes and ones, that each 1 lands on the mapped column, that the region skips columns 32 to 131 in the split mode, and that the completion latency is N+1 cycles. A mid-fill reset is also covered only by the bench.

// File: rtl/rdi_pkg.sv
package rdi_pkg;

  typedef enum logic [1:0] {
    MODE_ALLCOL = 2'd0,
    MODE_R65    = 2'd1,
    MODE_LR65   = 2'd2,
    MODE_R33    = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_CLOSE = 2'd2
  } rd_state_e;

endpackage

// File: rtl/rdi_region_map.sv
module rdi_region_map
  import rdi_pkg::*;
#(
  parameter int COLS  = 165,
  parameter int LINES = 65,
  parameter int HALF  = 33,
  localparam int CW = $clog2(COLS),
  localparam int LW = $clog2(LINES)
) (
  input  rd_mode_e        mode,
  output logic            has_region,
  output logic [CW-1:0]   start_col,
  output logic            gap_en,
  output logic [CW-1:0]   gap_from,
  output logic [CW-1:0]   gap_to,
  output logic [LW-1:0]   last_line
);

  localparam int WIDE_LO   = COLS - LINES;
  localparam int NARROW_LO = COLS - HALF;
  localparam int LEFT_HI   = LINES - HALF - 1;

  always_comb begin
    has_region = 1'b1;
    start_col  = CW'(WIDE_LO);
    gap_en     = 1'b0;
    gap_from   = CW'(LEFT_HI);
    gap_to     = CW'(NARROW_LO);
    last_line  = LW'(LINES - 1);
    unique case (mode)
      MODE_ALLCOL: begin
        has_region = 1'b0;
      end
      MODE_R65: begin
        start_col = CW'(WIDE_LO);
      end
      MODE_LR65: begin
        start_col = '0;
        gap_en    = 1'b1;
      end
      MODE_R33: begin
        start_col = CW'(NARROW_LO);
        last_line = LW'(HALF - 1);
      end
      default: has_region = 1'b0;
    endcase
  end

endmodule

// File: rtl/rdi_scan_ctr.sv
module rdi_scan_ctr #(
  parameter int COLS  = 165,
  parameter int LINES = 65,
  localparam int CW = $clog2(COLS),
  localparam int LW = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            advance,
  input  logic [CW-1:0]   start_col,
  input  logic            gap_en,
  input  logic [CW-1:0]   gap_from,
  input  logic [CW-1:0]   gap_to,
  input  logic [LW-1:0]   last_line,
  output logic [LW-1:0]   line,
  output logic [CW-1:0]   col,
  output logic            at_end
);

  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
      col  <= '0;
    end else if (load) begin
      line <= '0;
      col  <= start_col;
    end else if (advance) begin
      if (col == COL_LAST) begin
        col  <= start_col;
        line <= line + 1'b1;
      end else if (gap_en && col == gap_from) begin
        col <= gap_to;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  assign at_end = (line == last_line) && (col == COL_LAST);

endmodule

// File: rtl/rdi_target.sv
module rdi_target
  import rdi_pkg::*;
#(
  parameter int COLS  = 165,
  parameter int LINES = 65,
  parameter int HALF  = 33,
  localparam int CW = $clog2(COLS),
  localparam int LW = $clog2(LINES)
) (
  input  rd_mode_e        mode,
  input  logic [LW-1:0]   line,
  output logic [CW-1:0]   target_col
);

  localparam logic [CW-1:0] RIGHT_TOP = CW'(COLS - 1);
  localparam logic [CW-1:0] LEFT_TOP  = CW'(LINES - 1);

  logic [CW-1:0] line_w;
  assign line_w = CW'(line);

  always_comb begin
    if (mode == MODE_LR65 && line >= LW'(HALF))
      target_col = LEFT_TOP - line_w;
    else
      target_col = RIGHT_TOP - line_w;
  end

endmodule

// File: rtl/rdi_row_init.sv
module rdi_row_init
  import rdi_pkg::*;
#(
  parameter int COLS  = 165,
  parameter int LINES = 65,
  parameter int HALF  = 33,
  localparam int CW = $clog2(COLS),
  localparam int LW = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      mode,
  output logic            wr_en,
  output logic [LW-1:0]   wr_line,
  output logic [CW-1:0]   wr_col,
  output logic            wr_data,
  output logic            protect,
  output logic            busy,
  output logic            done
);

  rd_state_e state;
  rd_mode_e  mode_q;
  rd_mode_e  map_mode;

  logic          has_region;
  logic [CW-1:0] start_col, gap_from, gap_to, target_col;
  logic          gap_en;
  logic [LW-1:0] last_line, line;
  logic [CW-1:0] col;
  logic          at_end;
  logic          accept, ctr_load, ctr_adv;

  assign accept   = (state == ST_IDLE) && start;
  assign map_mode = (state == ST_IDLE) ? rd_mode_e'(mode) : mode_q;
  assign ctr_load = accept;
  assign ctr_adv  = (state == ST_RUN) && !at_end;

  rdi_region_map #(.COLS(COLS), .LINES(LINES), .HALF(HALF)) u_map (
    .mode       (map_mode),
    .has_region (has_region),
    .start_col  (start_col),
    .gap_en     (gap_en),
    .gap_from   (gap_from),
    .gap_to     (gap_to),
    .last_line  (last_line)
  );

  rdi_scan_ctr #(.COLS(COLS), .LINES(LINES)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (ctr_load),
    .advance   (ctr_adv),
    .start_col (start_col),
    .gap_en    (gap_en),
    .gap_from  (gap_from),
    .gap_to    (gap_to),
    .last_line (last_line),
    .line      (line),
    .col       (col),
    .at_end    (at_end)
  );

  rdi_target #(.COLS(COLS), .LINES(LINES), .HALF(HALF)) u_tgt (
    .mode       (mode_q),
    .line       (line),
    .target_col (target_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode_q  <= MODE_ALLCOL;
      wr_en   <= 1'b0;
      wr_line <= '0;
      wr_col  <= '0;
      wr_data <= 1'b0;
      protect <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q <= rd_mode_e'(mode);
            if (has_region) begin
              protect <= 1'b0;
              busy    <= 1'b1;
              state   <= ST_RUN;
            end else begin
              done <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          wr_en   <= 1'b1;
          wr_line <= line;
          wr_col  <= col;
          wr_data <= (col == target_col);
          if (at_end) state <= ST_CLOSE;
        end
        ST_CLOSE: begin
          protect <= 1'b1;
          busy    <= 1'b0;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rdi_row_init_chk.sv
module rdi_row_init_chk #(
  parameter int COLS  = 165,
  parameter int LINES = 65,
  parameter int HALF  = 33,
  localparam int CW = $clog2(COLS),
  localparam int LW = $clog2(LINES)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [1:0]    mode,
  input logic [1:0]    mode_q,
  input logic          wr_en,
  input logic [LW-1:0] wr_line,
  input logic [CW-1:0] wr_col,
  input logic          protect,
  input logic          busy,
  input logic          done
);

  a_r8_no_write_protected: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !protect);

  a_r8_done_protected: assert property (@(posedge clk) disable iff (rst)
    done |-> protect);

  a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_open_before_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !protect);

  a_r7_col_ascending: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && wr_line == $past(wr_line)) |-> wr_col > $past(wr_col));

  a_r7_line_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && wr_line != $past(wr_line)) |-> wr_line == $past(wr_line) + 1'b1);

  a_r3_col_bound: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_col < CW'(COLS)) && (wr_line < LW'(LINES)));

  a_r4_short_lines: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode_q == 2'd3) |-> wr_line < LW'(HALF));

  a_r2_allcol_done: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !done && !wr_en && protect && mode == 2'd0) |=> (done && !busy && protect));

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mode_q));

endmodule

bind rdi_row_init rdi_row_init_chk #(.COLS(COLS), .LINES(LINES), .HALF(HALF)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .mode    (mode),
  .mode_q  (mode_q),
  .wr_en   (wr_en),
  .wr_line (wr_line),
  .wr_col  (wr_col),
  .protect (protect),
  .busy    (busy),
  .done    (done)
);

// File: tb/rdi_row_init_bench.sv
module rdi_row_init_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       wr_en, wr_data, protect, busy, done;
  logic [6:0] wr_line;
  logic [7:0] wr_col;

  always #4 clk = ~clk;

  rdi_row_init u_rdi_row_init (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .wr_en(wr_en), .wr_line(wr_line), .wr_col(wr_col), .wr_data(wr_data),
    .protect(protect), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;

  // mode, expected writes, expected ones
  localparam int VEC [4][3] = '{
    '{0, 0,    0},
    '{1, 4225, 65},
    '{2, 4225, 65},
    '{3, 1089, 33}
  };

  int run_mode = 0;
  int n_wr, n_one, data_bad, reg_bad, prot_bad, ord_bad;
  int prev_key;
  logic prev_we = 1'b0;

  function automatic bit in_region(int m, int l, int c);
    if (c > 164) return 0;
    case (m)
      1: return (l < 65) && (c >= 100);
      2: return (l < 65) && ((c <= 31) || (c >= 132));
      3: return (l < 33) && (c >= 132);
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_bit(int m, int l, int c);
    int t;
    t = (m == 2 && l >= 33) ? 64 - l : 164 - l;
    return in_region(m, l, c) && (c == t);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_tally();
    n_wr = 0; n_one = 0; data_bad = 0; reg_bad = 0; prot_bad = 0; ord_bad = 0;
    prev_key = -1;
  endtask

  always @(negedge clk) begin
    if (wr_en) begin
      n_wr++;
      if (wr_data) n_one++;
      if (wr_data != exp_bit(run_mode, int'(wr_line), int'(wr_col))) data_bad++;
      if (!in_region(run_mode, int'(wr_line), int'(wr_col))) reg_bad++;
      if (protect) prot_bad++;
      if (n_wr > 1 && !prev_we) ord_bad++;
      if (int'(wr_line) * 256 + int'(wr_col) <= prev_key) ord_bad++;
      prev_key = int'(wr_line) * 256 + int'(wr_col);
    end
    prev_we = wr_en;
  end

  // pulse start at a negedge; returns cycles from acceptance edge to done
  task automatic run_fill(input int m, output int lat, output int prot_after);
    @(negedge clk);
    mode = 2'(m); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    prot_after = int'(protect);
    lat = 0;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog expired actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat, pa;
    clear_tally();
    repeat (3) @(negedge clk);
    chk("R1 protect in reset", int'(protect), 1);
    chk("R1 wr_en in reset", int'(wr_en), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle busy/done", int'(busy) + int'(done), 0);

    for (int i = 0; i < 4; i++) begin
      clear_tally();
      run_mode = VEC[i][0];
      run_fill(VEC[i][0], lat, pa);
      chk($sformatf("R8 latency mode %0d", VEC[i][0]), lat,
          VEC[i][1] == 0 ? 0 : VEC[i][1] + 1);
      chk($sformatf("R8 protect after start mode %0d", VEC[i][0]), pa,
          VEC[i][1] == 0 ? 1 : 0);
      chk($sformatf("R8 protect at done mode %0d", VEC[i][0]), int'(protect), 1);
      chk($sformatf("R10 busy at done mode %0d", VEC[i][0]), int'(busy), 0);
      chk($sformatf("R3 R4 R5 write count mode %0d", VEC[i][0]), n_wr, VEC[i][1]);
      chk($sformatf("R6 ones count mode %0d", VEC[i][0]), n_one, VEC[i][2]);
      chk($sformatf("R6 data mismatches mode %0d", VEC[i][0]), data_bad, 0);
      chk($sformatf("R3 R4 R5 out of region mode %0d", VEC[i][0]), reg_bad, 0);
      chk($sformatf("R8 writes while protected mode %0d", VEC[i][0]), prot_bad, 0);
      chk($sformatf("R7 order/gap faults mode %0d", VEC[i][0]), ord_bad, 0);
      @(negedge clk);
      chk($sformatf("R8 done one cycle mode %0d", VEC[i][0]), int'(done), 0);
    end

    // R2: all-column mode never drops protection
    chk("R2 protect stays high", int'(protect), 1);

    // R9: start while busy is ignored
    clear_tally();
    run_mode = 3;
    @(negedge clk);
    mode = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    mode = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 R10 busy kept after extra start", int'(busy), 1);
    while (!done) @(negedge clk);
    chk("R9 write count unchanged", n_wr, 1089);
    chk("R9 data follows first mode", data_bad, 0);
    @(negedge clk);
    chk("R9 no second fill", int'(busy), 0);

    // R1: reset during a fill
    clear_tally();
    run_mode = 1;
    @(negedge clk);
    mode = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 protect after mid reset", int'(protect), 1);
    chk("R1 idle after mid reset", int'(busy) + int'(wr_en) + int'(done), 0);
    repeat (5) @(negedge clk);
    chk("R1 fill abandoned", int'(wr_en), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule